// File: doc/BRIEF.md
# I2C Heading Sensor Poller

This block is a single-master I2C controller that polls a magnetic heading sensor without software help. Each poll runs two bus transactions. The first one addresses the sensor for writing and sends it a "take a measurement" command. The block then waits long enough for the sensor to compute a result. The second transaction addresses the sensor for reading and pulls back a two-byte heading. The heading arrives in tenths of a degree, measured clockwise from magnetic north.

Both bus lines are open-drain. The block only produces an enable for each line: when an enable is high, the pad pulls that line to ground. When it is low, the line floats and an external resistor pulls it high. The returned value appears on a 16-bit output together with a one-cycle strobe. A parameterised start-up delay comes before the first poll, and a parameterised gap separates later polls.

All bus timing is built from one quarter-period count of system clocks. The quarter-period is the basic unit: SCL stays low for two quarters, then high for two quarters.

Top module: `i2c_heading_poller`

## Requirements
- R1: While reset is held, and on the first cycle after it, `scl_oe`, `sda_oe` and `heading_vld` are 0 and `heading` is 0.
- R2: The first START occurs no earlier than BOOT_CYC clocks after reset is released, and no later than BOOT_CYC + 4·QTR_CYC clocks after it.
- R3: Within a transaction, every SCL high pulse lasts exactly 2·QTR_CYC clocks. When `sda_oe` changes while SCL is low, the change comes exactly QTR_CYC clocks after SCL fell. `scl_oe` and `sda_oe` never change in the same cycle.
- R4: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A write transaction carries exactly two bytes between its START and its STOP. A read transaction carries one address byte and two data bytes.
- R5: The measure transaction sends address byte WR_ADDR (default 0x42, whose bit 0 = 0 means write), then command byte MEAS_CMD (default 0x41). Bytes go out MSB first, with enable high meaning a 0 bit.
- R6: In the ninth clock after each byte the master sends, `sda_oe` is 0. The acknowledge value the slave returns has no effect: the poll completes and delivers its heading even when the command byte is not acknowledged.
- R7: From the STOP of the measure transaction to the START of the read transaction, at least MEAS_CYC clocks pass and at most MEAS_CYC + 4·QTR_CYC. Both enables are 0 while the block waits.
- R8: The read transaction sends address byte RD_ADDR (default 0x43, whose bit 0 = 1 means read), then shifts in two bytes. The first byte received becomes `heading[15:8]` and the second becomes `heading[7:0]`, each MSB first.
- R9: After each received byte, the master holds SDA low for the whole ninth clock, from before SCL rises until after SCL falls.
- R10: `heading_vld` is a single-cycle pulse issued after the read STOP. `heading` changes only in that cycle and holds its value until the next pulse.
- R11: From the STOP of a read transaction to the next START, at least GAP_CYC clocks pass and at most GAP_CYC + 4·QTR_CYC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_in | input | 1 | Level of the SDA line as seen at the pad |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| heading | output | 16 | Last heading read, tenths of a degree |
| heading_vld | output | 1 | One-cycle pulse when `heading` is updated |

## Verification
The bench builds the block with QTR_CYC = 4, BOOT_CYC = 300, MEAS_CYC = 500 and GAP_CYC = 400, instead of the real-time defaults. These values make one whole poll take under two thousand clocks, so five consecutive polls fit easily into a run. The short quarter-period still leaves room to measure the exact spacing of each SDA change and the exact SCL high time. The bench includes a small slave model on the wired-AND bus. It serves a different heading on every poll, including the extreme values 0x0000 and 0xFFFF, and it withholds the command acknowledge on one poll.

// File: rtl/i2c_heading_poller.sv
module i2c_heading_poller #(
  parameter int          QTR_CYC  = 250,
  parameter int          BOOT_CYC = 100_000_000,
  parameter int          MEAS_CYC = 700_000,
  parameter int          GAP_CYC  = 100_000_000,
  parameter logic [7:0]  WR_ADDR  = 8'h42,
  parameter logic [7:0]  MEAS_CMD = 8'h41,
  parameter logic [7:0]  RD_ADDR  = 8'h43
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic [15:0] heading,
  output logic        heading_vld
);

  localparam int QW    = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam int TMAX0 = (BOOT_CYC > MEAS_CYC) ? BOOT_CYC : MEAS_CYC;
  localparam int TMAX  = (TMAX0 > GAP_CYC) ? TMAX0 : GAP_CYC;
  localparam int TW    = $clog2(TMAX + 1);

  localparam logic [1:0] ST_WAIT  = 2'd0;
  localparam logic [1:0] ST_START = 2'd1;
  localparam logic [1:0] ST_BITS  = 2'd2;
  localparam logic [1:0] ST_STOP  = 2'd3;

  logic [1:0]    st;
  logic [QW-1:0] qcnt;
  logic [1:0]    qtr;
  logic [3:0]    bit_idx;
  logic [2:0]    byte_idx;
  logic [TW-1:0] tmr;
  logic [15:0]   rx;
  logic          sda_drv;
  logic [7:0]    tx_byte;
  logic          drive_next;

  wire busy     = (st != ST_WAIT);
  wire qtick    = busy && (qcnt == QW'(QTR_CYC - 1));
  wire step_end = qtick && (qtr == 2'd3);
  wire rd_byte  = (byte_idx >= 3'd3);
  wire data_bit = !bit_idx[3];
  wire tx_bit   = tx_byte[3'd7 - bit_idx[2:0]];

  always_comb begin
    case (byte_idx)
      3'd0:    tx_byte = WR_ADDR;
      3'd1:    tx_byte = MEAS_CMD;
      default: tx_byte = RD_ADDR;
    endcase
  end

  always_comb begin
    if (data_bit) drive_next = rd_byte ? 1'b0 : !tx_bit;
    else          drive_next = rd_byte;
  end

  assign scl_oe = (st == ST_START) ? (qtr == 2'd3) :
                  (st == ST_BITS || st == ST_STOP) ? (qtr < 2'd2) : 1'b0;
  assign sda_oe = sda_drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_WAIT;
      qcnt        <= '0;
      qtr         <= '0;
      bit_idx     <= '0;
      byte_idx    <= '0;
      tmr         <= TW'(BOOT_CYC - 1);
      rx          <= '0;
      sda_drv     <= 1'b0;
      heading     <= '0;
      heading_vld <= 1'b0;
    end else begin
      heading_vld <= 1'b0;
      if (busy) qcnt <= qtick ? '0 : qcnt + 1'b1;
      if (qtick) qtr <= qtr + 2'd1;
      case (st)
        ST_WAIT: begin
          if (tmr == '0) st <= ST_START;
          else           tmr <= tmr - 1'b1;
        end
        ST_START: begin
          if (qtick && qtr == 2'd0) sda_drv <= 1'b1;
          if (step_end) begin
            st      <= ST_BITS;
            bit_idx <= '0;
          end
        end
        ST_BITS: begin
          if (qtick && qtr == 2'd0) sda_drv <= drive_next;
          if (qtick && qtr == 2'd2 && rd_byte && data_bit) rx <= {rx[14:0], sda_in};
          if (step_end) begin
            if (data_bit) begin
              bit_idx <= bit_idx + 4'd1;
            end else begin
              bit_idx  <= '0;
              byte_idx <= byte_idx + 3'd1;
              if (byte_idx == 3'd1 || byte_idx == 3'd4) st <= ST_STOP;
            end
          end
        end
        default: begin
          if (qtick && qtr == 2'd0) sda_drv <= 1'b1;
          if (qtick && qtr == 2'd2) sda_drv <= 1'b0;
          if (step_end) begin
            st <= ST_WAIT;
            if (byte_idx == 3'd2) begin
              tmr <= TW'(MEAS_CYC - 1);
            end else begin
              tmr         <= TW'(GAP_CYC - 1);
              byte_idx    <= '0;
              heading     <= rx;
              heading_vld <= 1'b1;
            end
          end
        end
      endcase
    end
  end

endmodule

module i2c_heading_poller_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic [15:0] heading,
  input logic        heading_vld,
  input logic [1:0]  st
);

  // R3
  lines_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_oe) |-> $stable(sda_oe));

  // R4
  start_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && !scl_oe) |-> (st == 2'd1));

  // R4
  stop_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && !scl_oe) |-> (st == 2'd3));

  // R7
  wait_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> (!scl_oe && !sda_oe));

  // R10
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    heading_vld |=> !heading_vld);

  // R10
  heading_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(heading) |-> heading_vld);

endmodule

bind i2c_heading_poller i2c_heading_poller_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .heading(heading), .heading_vld(heading_vld), .st(st)
);

// File: tb/i2c_heading_poller_test.sv
module i2c_heading_poller_test;
  localparam int Q    = 4;
  localparam int BOOT = 300;
  localparam int MEAS = 500;
  localparam int GAP  = 400;
  localparam int NPOLL = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic pull = 0;
  logic scl_oe, sda_oe, heading_vld;
  logic [15:0] heading;
  wire  sda_in = !(sda_oe | pull);

  always #5 clk = !clk;

  i2c_heading_poller #(.QTR_CYC(Q), .BOOT_CYC(BOOT), .MEAS_CYC(MEAS), .GAP_CYC(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .heading(heading), .heading_vld(heading_vld));

  int n_chk = 0, n_bad = 0, cyc = 0, n_got = 0;
  logic [15:0] tx_q[$];
  logic [15:0] exp_q[$];
  bit          nack_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic serve(input logic [15:0] v, input bit nack);
    tx_q.push_back(v);
    exp_q.push_back(v);
    nack_q.push_back(nack);
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // slave model and bus timing monitor
  bit p_scl = 1, p_sda = 1, p_oe = 0;
  bit in_txn = 0, rise_in = 0, is_wr = 0, exp_wr = 1, slave_tx = 0, pend_rd = 0;
  bit cur_nack = 0, ack_chk = 0, first = 1, last_wr = 0;
  int bitcnt = 0, byte_pos = 0, rd_idx = 0, hi_cnt = 0, lo_cnt = 0, stop_t = 0;
  logic [7:0]  sh = 0;
  logic [15:0] cur_val = 0, last_hd = 0;

  task automatic record(input logic [7:0] b);
    if (byte_pos == 0) begin
      is_wr = !b[0];
      check(b == (exp_wr ? 8'h42 : 8'h43), exp_wr ? "R5 address" : "R8 address", b, exp_wr ? 8'h42 : 8'h43);
      if (!is_wr) begin
        pend_rd = 1;
        cur_val = (tx_q.size() > 0) ? tx_q.pop_front() : 16'h0;
      end else begin
        cur_nack = (nack_q.size() > 0) ? nack_q.pop_front() : 1'b0;
      end
    end else if (byte_pos == 1) begin
      check(b == 8'h41, "R5 command", b, 8'h41);
    end
    byte_pos++;
  endtask

  always @(negedge clk) if (rst_n) begin
    automatic bit scl_l = !scl_oe;
    automatic bit sda_l = sda_in;
    automatic logic [7:0] v;
    if (scl_l && p_scl && p_sda && !sda_l) begin
      if (first) begin
        check(cyc >= BOOT && cyc <= BOOT + 4*Q, "R2", cyc, BOOT);
        first = 0;
      end else if (last_wr) begin
        check(cyc - stop_t >= MEAS && cyc - stop_t <= MEAS + 4*Q, "R7", cyc - stop_t, MEAS);
      end else begin
        check(cyc - stop_t >= GAP && cyc - stop_t <= GAP + 4*Q, "R11", cyc - stop_t, GAP);
      end
      check(heading == last_hd, "R10 hold", heading, last_hd);
      in_txn = 1; rise_in = 0; byte_pos = 0; bitcnt = 0; slave_tx = 0; pend_rd = 0; rd_idx = 0;
    end else if (scl_l && p_scl && !p_sda && sda_l) begin
      if (is_wr) check(byte_pos == 2, "R4 write frame", byte_pos, 2);
      else       check(byte_pos == 1 && rd_idx == 2, "R4 read frame", rd_idx, 2);
      stop_t = cyc; in_txn = 0; rise_in = 0; last_wr = is_wr; exp_wr = !exp_wr;
    end else if (scl_l && !p_scl) begin
      if (in_txn) begin
        rise_in = 1; hi_cnt = 1;
        if (bitcnt < 8) begin
          sh = {sh[6:0], sda_l};
          bitcnt++;
          if (bitcnt == 8 && !slave_tx) record(sh);
        end else begin
          if (slave_tx) begin
            check(sda_l == 0, "R9 rise", sda_l, 0);
            ack_chk = 1; rd_idx++;
          end else begin
            check(sda_oe == 0, "R6 release", sda_oe, 0);
          end
          bitcnt = 0;
          if (pend_rd) begin slave_tx = 1; pend_rd = 0; end
        end
      end
    end else if (!scl_l && p_scl) begin
      if (in_txn && rise_in) check(hi_cnt == 2*Q, "R3 high", hi_cnt, 2*Q);
      lo_cnt = 0;
      if (ack_chk) begin
        check(p_sda == 0 && sda_l == 0, "R9 fall", sda_l, 0);
        ack_chk = 0;
      end
      if (bitcnt == 8 && !slave_tx) pull = !(cur_nack && byte_pos == 2);
      else if (slave_tx && bitcnt < 8 && rd_idx < 2) begin
        v = (rd_idx == 0) ? cur_val[15:8] : cur_val[7:0];
        pull = !v[7 - bitcnt];
      end else pull = 0;
    end else if (scl_l) hi_cnt++;
    else lo_cnt++;
    if (in_txn && !scl_l && sda_oe != p_oe) check(lo_cnt == Q, "R3 sda quarter", lo_cnt, Q);
    p_scl = scl_l; p_sda = !(sda_oe | pull); p_oe = sda_oe;
  end

  // scoreboard monitor
  bit p_vld = 0;
  always @(negedge clk) if (rst_n) begin
    if (p_vld) check(!heading_vld, "R10 pulse", heading_vld, 0);
    if (heading_vld) begin
      automatic logic [15:0] e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hDEAD;
      check(heading == e, "R8 heading (R6 when nacked)", heading, e);
      last_hd = heading;
      n_got++;
    end
    p_vld = heading_vld;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(!scl_oe && !sda_oe && !heading_vld && heading == 0, "R1 in reset",
          {scl_oe, sda_oe, heading_vld}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!scl_oe && !sda_oe && !heading_vld && heading == 0, "R1 after reset",
          {scl_oe, sda_oe, heading_vld}, 0);
    serve(16'h0E0F, 0);
    serve(16'hA55A, 1);
    serve(16'h0000, 0);
    serve(16'hFFFF, 0);
    serve(16'h0708, 0);
    while (n_got < NPOLL && cyc < 50000) @(negedge clk);
    if (n_got < NPOLL) check(0, "watchdog", n_got, NPOLL);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule